// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog with a small register window on a 16-bit, byte-addressed bus. Software sets a tick count, releases the halt bit, and then has to keep writing the reload register. If it stops doing so, the counter runs down and the block escalates in two steps. The first expiry sets a sticky timeout flag and, if enabled, sends a one-cycle interrupt pulse to the system-management handler. The counter then reloads itself. If it runs down again while that flag is still set, the block sets a second-timeout flag and sends a one-cycle reboot pulse. A no-reboot gate bit can block that pulse.

A prescaler turns the input clock into the counter tick. `TICK_CYCLES` clocks make one tick, and the default gives 0.6 s at 125 MHz. The reset-time count comes from a number of seconds, converted as seconds*10/6 ticks. All registers are 16 bits wide and sit at even offsets. Writes take effect at the clock edge on which `wr_en` is sampled. Reads are combinational from `addr`.

Top module: `wdt2_top`

## Requirements
- R1: After reset the registers read as follows: control (0x08) = 0x0802 (halted, reboot blocked, interrupt off); initial value (0x12) = 0x0005; count (0x00) = 5; status 0x04 = 0x0000; status 0x06 = 0x0004. Both `smi_req` and `reboot_req` are low.
- R2: The initial-value register at 0x12 holds the tick count in bits [9:0] and general storage in bits [15:10]. Reading it returns exactly what was written.
- R3: A write to 0x12 whose bits [9:0] are 0 to 3 leaves the tick count unchanged. Bits [15:10] are still written.
- R4: A write to 0x00 with bit 0 set loads the counter from the initial value and restarts the prescaler. Reading 0x00 returns the current count in bits [9:0]. Reloading more often than once per expiry period keeps the timeout flag clear.
- R5: Bit 11 of the control register at 0x08 is the halt bit. While it is 1 the count does not change, and the bit reads back as written.
- R6: While running, the count drops by one every `TICK_CYCLES` clocks. A tick that finds the count at 0 is an expiry, and that expiry reloads the initial value. A full period is therefore (initial value + 1) ticks.
- R7: The first expiry, with bit 3 of 0x04 clear, sets that bit. If control bit 0 is 1, it also raises `smi_req` for exactly one cycle, visible one clock after the expiry edge.
- R8: An expiry while bit 3 of 0x04 is set does two things. It sets bit 1 of 0x06. It also raises `reboot_req` for exactly one cycle, unless the no-reboot bit (control bit 1) is 1, in which case `reboot_req` stays low.
- R9: Writing 1 to bit 3 of 0x04 or to bit 1 of 0x06 clears that flag. Writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: Bit 2 of 0x06 is a boot flag. It reads 1 after reset and is cleared by writing 1 to it.
- R11: The no-reboot bit (control bit 1) and the interrupt-enable bit (control bit 0) read back as written. The undefined control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| smi_req | output | 1 | One-cycle interrupt request on the first expiry |
| reboot_req | output | 1 | One-cycle reboot request on the second expiry |

## Verification
The bench counts from the clock edge that clears the halt bit. With `TICK_CYCLES`=4 and an initial value of 5, the count has dropped by one after each group of 4 edges. The first expiry lands on edge 24 and the second on edge 48. Each pulse is checked low one cycle early, high on the due cycle and low again one cycle later.

Register reads are combinational, so a register update is checked one clock after the edge that writes it. All samples are taken on the falling edge, with inputs driven at that same point.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 16;

  // register offsets (software decodes these)
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STS1   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STS2   = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

  // bit positions
  localparam int B_TIMEOUT = 3;   // status 0x04
  localparam int B_SECOND  = 1;   // status 0x06
  localparam int B_BOOT    = 2;   // status 0x06
  localparam int B_HALT    = 11;  // control
  localparam int B_NOREB   = 1;   // control
  localparam int B_IRQEN   = 0;   // control

  localparam int MIN_TICKS = 4;

  // one tick is 0.6 s
  function automatic int secs_to_ticks(input int secs);
    return (secs * 10) / 6;
  endfunction

  function automatic logic init_ok(input logic [REG_W-1:0] v);
    return v >= REG_W'(MIN_TICKS);
  endfunction
endpackage

// File: rtl/wdt2_prescale.sv
module wdt2_prescale #(
  parameter int TICK_CYCLES = 75_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                div_q <= '0;
    else if (restart || !run)  div_q <= '0;
    else if (tick)             div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  a_r5_no_tick_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int CNT_W = 10,
  parameter logic [CNT_W-1:0] RST_COUNT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = tick && !reload && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= RST_COUNT;
    else if (reload || expire) count <= init_val;
    else if (tick)             count <= count - 1'b1;
  end

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && count != '0) |=> count == $past(count) - 1'b1);
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> count == $past(init_val));
  a_r6_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(init_val));
endmodule

// File: rtl/wdt2_status.sv
module wdt2_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic no_reboot,
  input  logic clr_timeout,
  input  logic clr_second,
  input  logic clr_boot,
  output logic sts_timeout,
  output logic sts_second,
  output logic sts_boot,
  output logic smi_req,
  output logic reboot_req,
  output logic first_exp,
  output logic second_exp
);
  assign first_exp  = expire && !sts_timeout;
  assign second_exp = expire && sts_timeout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_timeout <= 1'b0;
      sts_second  <= 1'b0;
      sts_boot    <= 1'b1;
      smi_req     <= 1'b0;
      reboot_req  <= 1'b0;
    end else begin
      sts_timeout <= first_exp  || (sts_timeout && !clr_timeout);
      sts_second  <= second_exp || (sts_second && !clr_second);
      sts_boot    <= sts_boot && !clr_boot;
      smi_req     <= first_exp && irq_en;
      reboot_req  <= second_exp && !no_reboot;
    end
  end

  a_r7_smi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> sts_timeout);
  a_r7_smi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |=> !smi_req);
  a_r8_reboot_gate: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> (sts_second && !$past(no_reboot)));
  a_r8_reboot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_second && !second_exp) |=> !sts_second);
  a_r10_boot_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sts_boot));
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter logic [CNT_W-1:0] RST_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              sts_timeout,
  input  logic              sts_second,
  input  logic              sts_boot,
  output logic [REG_W-1:0]  rd_data,
  output logic              halt,
  output logic              irq_en,
  output logic              no_reboot,
  output logic [CNT_W-1:0]  init_val,
  output logic              reload_wr,
  output logic              clr_timeout,
  output logic              clr_second,
  output logic              clr_boot
);
  localparam int HI_W = REG_W - CNT_W;

  logic [HI_W-1:0] init_hi;
  logic wr_init, wr_ctrl, wr_sts1, wr_sts2;
  logic unused_bits;

  assign wr_init   = wr_en && (addr == OFS_INIT);
  assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
  assign wr_sts1   = wr_en && (addr == OFS_STS1);
  assign wr_sts2   = wr_en && (addr == OFS_STS2);
  assign reload_wr = wr_en && (addr == OFS_RELOAD) && wr_data[0];

  assign clr_timeout = wr_sts1 && wr_data[B_TIMEOUT];
  assign clr_second  = wr_sts2 && wr_data[B_SECOND];
  assign clr_boot    = wr_sts2 && wr_data[B_BOOT];

  assign unused_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt      <= 1'b1;
      no_reboot <= 1'b1;
      irq_en    <= 1'b0;
      init_val  <= RST_INIT;
      init_hi   <= '0;
    end else begin
      if (wr_ctrl) begin
        halt      <= wr_data[B_HALT];
        no_reboot <= wr_data[B_NOREB];
        irq_en    <= wr_data[B_IRQEN];
      end
      if (wr_init) begin
        init_hi <= wr_data[REG_W-1:CNT_W];
        if (init_ok(REG_W'(wr_data[CNT_W-1:0])))
          init_val <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      OFS_RELOAD: rd_data[CNT_W-1:0] = count;
      OFS_STS1:   rd_data[B_TIMEOUT] = sts_timeout;
      OFS_STS2: begin
        rd_data[B_SECOND] = sts_second;
        rd_data[B_BOOT]   = sts_boot;
      end
      OFS_CTRL: begin
        rd_data[B_HALT]  = halt;
        rd_data[B_NOREB] = no_reboot;
        rd_data[B_IRQEN] = irq_en;
      end
      OFS_INIT:   rd_data = {init_hi, init_val};
      default:    rd_data = '0;
    endcase
  end

  a_r3_reject_small: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && !init_ok(REG_W'(wr_data[CNT_W-1:0]))) |=> $stable(init_val));
  a_r2_init_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && init_ok(REG_W'(wr_data[CNT_W-1:0]))) |=> init_val == $past(wr_data[CNT_W-1:0]));
  a_r11_ctrl_take: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (no_reboot == $past(wr_data[B_NOREB]) && halt == $past(wr_data[B_HALT])));
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int TICK_CYCLES   = 75_000_000,
  parameter int CNT_W         = 10,
  parameter int RESET_SECONDS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              smi_req,
  output logic              reboot_req
);
  localparam logic [CNT_W-1:0] RST_TICKS = CNT_W'(secs_to_ticks(RESET_SECONDS));

  logic             tick, expire, first_exp, second_exp;
  logic             halt, irq_en, no_reboot, reload_wr;
  logic             clr_timeout, clr_second, clr_boot;
  logic             sts_timeout, sts_second, sts_boot;
  logic [CNT_W-1:0] count, init_val;

  wdt2_regs #(.CNT_W(CNT_W), .RST_INIT(RST_TICKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .count(count), .sts_timeout(sts_timeout), .sts_second(sts_second),
    .sts_boot(sts_boot), .rd_data(rd_data), .halt(halt), .irq_en(irq_en),
    .no_reboot(no_reboot), .init_val(init_val), .reload_wr(reload_wr),
    .clr_timeout(clr_timeout), .clr_second(clr_second), .clr_boot(clr_boot)
  );

  wdt2_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload_wr), .tick(tick)
  );

  wdt2_counter #(.CNT_W(CNT_W), .RST_COUNT(RST_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_wr),
    .init_val(init_val), .count(count), .expire(expire)
  );

  wdt2_status u_sts (
    .clk(clk), .rst_n(rst_n), .expire(expire), .irq_en(irq_en),
    .no_reboot(no_reboot), .clr_timeout(clr_timeout), .clr_second(clr_second),
    .clr_boot(clr_boot), .sts_timeout(sts_timeout), .sts_second(sts_second),
    .sts_boot(sts_boot), .smi_req(smi_req), .reboot_req(reboot_req),
    .first_exp(first_exp), .second_exp(second_exp)
  );

  a_r5_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_wr) |=> $stable(count));
  a_r8_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_second) |-> $past(sts_timeout));
  a_r7_exp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(first_exp && second_exp));
endmodule

// File: tb/wdt2_top_test.sv
module wdt2_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        smi_req, reboot_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wdt2_top #(.TICK_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .smi_req(smi_req), .reboot_req(reboot_req)
  );

  // {is_write, req, addr, data, expected}
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 4'd3,  5'h12, 16'h0003, 16'h0000},
    {1'b0, 4'd3,  5'h12, 16'h0000, 16'h0005},
    {1'b1, 4'd2,  5'h12, 16'hFC07, 16'h0000},
    {1'b0, 4'd2,  5'h12, 16'h0000, 16'hFC07},
    {1'b1, 4'd3,  5'h12, 16'h0402, 16'h0000},
    {1'b0, 4'd3,  5'h12, 16'h0000, 16'h0407},
    {1'b1, 4'd2,  5'h12, 16'h0005, 16'h0000},
    {1'b0, 4'd2,  5'h12, 16'h0000, 16'h0005},
    {1'b1, 4'd11, 5'h08, 16'hFFFF, 16'h0000},
    {1'b0, 4'd11, 5'h08, 16'h0000, 16'h0803},
    {1'b1, 4'd9,  5'h04, 16'h0008, 16'h0000},
    {1'b0, 4'd9,  5'h04, 16'h0000, 16'h0000},
    {1'b0, 4'd5,  5'h00, 16'h0000, 16'h0005}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    chk_rd("R1 ctrl", 5'h08, 16'h0802);
    chk_rd("R1 init", 5'h12, 16'h0005);
    chk_rd("R1 count", 5'h00, 16'h0005);
    chk_rd("R1 sts1", 5'h04, 16'h0000);
    chk_rd("R1 sts2", 5'h06, 16'h0004);
    chk("R1 smi", {15'd0, smi_req}, 16'h0);
    chk("R1 reboot", {15'd0, reboot_req}, 16'h0);

    // R5 halted after reset: count frozen
    wait_n(40);
    chk_rd("R5 halted count", 5'h00, 16'h0005);

    // register vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) wr(VEC[i][36:32], VEC[i][31:16]);
      else begin
        logic [15:0] v;
        rd(VEC[i][36:32], v);
        n_chk++;
        if (v !== VEC[i][15:0]) begin
          n_bad++;
          $display("FAIL R%0d vector %0d: actual 0x%04h expected 0x%04h",
                   VEC[i][40:37], i, v, VEC[i][15:0]);
        end
      end
    end

    // R6/R7/R8: run with interrupt on and reboot allowed
    wr(5'h00, 16'h0001);
    wr(5'h08, 16'h0001);          // edge E0, n = 0
    wait_n(8);
    chk_rd("R6 count after 2 ticks", 5'h00, 16'h0003);
    wait_n(15);                   // n = 23
    chk("R7 smi early", {15'd0, smi_req}, 16'h0);
    chk_rd("R7 flag early", 5'h04, 16'h0000);
    wait_n(1);                    // n = 24
    chk("R7 smi due", {15'd0, smi_req}, 16'h1);
    chk_rd("R7 flag set", 5'h04, 16'h0008);
    chk_rd("R6 self reload", 5'h00, 16'h0005);
    wait_n(1);                    // n = 25
    chk("R7 smi one cycle", {15'd0, smi_req}, 16'h0);
    wait_n(22);                   // n = 47
    chk("R8 reboot early", {15'd0, reboot_req}, 16'h0);
    wait_n(1);                    // n = 48
    chk("R8 reboot due", {15'd0, reboot_req}, 16'h1);
    chk_rd("R8 second flag", 5'h06, 16'h0006);
    wait_n(1);
    chk("R8 reboot one cycle", {15'd0, reboot_req}, 16'h0);

    // R9 / R10: write-1-to-clear
    wr(5'h08, 16'h0802);
    wr(5'h04, 16'h0000);
    chk_rd("R9 write 0 keeps", 5'h04, 16'h0008);
    wr(5'h04, 16'h0008);
    chk_rd("R9 clear timeout", 5'h04, 16'h0000);
    wr(5'h06, 16'h0002);
    chk_rd("R9 clear second", 5'h06, 16'h0004);
    wr(5'h06, 16'h0004);
    chk_rd("R10 clear boot", 5'h06, 16'h0000);

    // R7 enable off, R8 gate on
    wr(5'h00, 16'h0001);
    wr(5'h08, 16'h0002);          // E1, n = 0
    wait_n(24);
    chk("R7 smi gated", {15'd0, smi_req}, 16'h0);
    chk_rd("R7 flag without irq", 5'h04, 16'h0008);
    wait_n(24);                   // n = 48
    chk("R8 reboot gated", {15'd0, reboot_req}, 16'h0);
    chk_rd("R8 flag despite gate", 5'h06, 16'h0002);
    chk_rd("R11 no-reboot readback", 5'h08, 16'h0002);

    // R4 regular reloads prevent expiry
    wr(5'h04, 16'h0008);
    for (int k = 0; k < 4; k++) begin
      wr(5'h00, 16'h0001);
      wait_n(19);
    end
    chk_rd("R4 no expiry", 5'h04, 16'h0000);
    chk_rd("R4 count after reload", 5'h00, 16'h0001);

    // R1 reset mid-run
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
    chk_rd("R1 ctrl after rerun reset", 5'h08, 16'h0802);
    chk_rd("R1 count after rerun reset", 5'h00, 16'h0005);
    chk_rd("R1 sts2 after rerun reset", 5'h06, 16'h0004);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule